// File: doc/BRIEF.md
# Banked Data Memory Address Unit

This block sits between an 8-bit core's instruction decoder and its data register file. Each cycle it forms a 12-bit effective address and performs a byte read or write. The address comes from one of two paths. The direct path combines an 8-bit operand with a bank register, or with a fixed overlay when the access flag is raised. The indirect path takes one of three 12-bit pointer registers and ignores banking.

The effective address is decoded into three regions. General-purpose RAM holds the contents. A special-function-register window is forwarded on a dedicated port so that peripheral registers can live outside the block. All other addresses read as zero, and writes to them are dropped. The bank register and the pointers are loaded through their own write ports. The bank register can be read back.

Top module: `bank_addr_unit`

## Requirements
- R1: With `req_indirect`=0 and `access_flag`=0, `eff_addr` equals {bank[3:0], `opnd`}.
- R2: A bank register write keeps only `bank_wr_data[3:0]`. After the write, `bank_rd` shows those four bits with bits 7:4 read as zero.
- R3: With `req_indirect`=0 and `access_flag`=1, the bank register is ignored. `opnd` 0x00–0x5F maps to 0x000–0x05F, and 0x60–0xFF maps to 0xF60–0xFFF.
- R4: With `req_indirect`=1, `eff_addr` equals the full 12-bit pointer picked by `ptr_sel` (0, 1 or 2), whatever the bank register holds.
- R5: Addresses 0x000–0x2FF are RAM. A write is stored at the clock edge that ends the request cycle. A read places the byte on `rdata` after the edge that ends the request cycle. `rdata` holds its value in cycles without a read.
- R6: Addresses 0xF60–0xFFF raise `sfr_sel` during a valid request, with `sfr_addr` set to the low 8 address bits. `sfr_we` is raised for writes and `sfr_wdata` carries the byte. For a read, `sfr_rdata` is captured into `rdata`.
- R7: Addresses 0x300–0xF5F are unimplemented. Reads there return 0x00. Writes there change no RAM byte and do not raise `sfr_we`.
- R8: Reset clears the bank register, all three pointers and `rdata`. It does not clear the RAM.
- R9: A bank or pointer write issued in the same cycle as an access takes effect at the next edge. The access uses the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_indirect | input | 1 | Use pointer path instead of direct path |
| ptr_sel | input | 2 | Pointer used by an indirect access |
| opnd | input | 8 | Direct operand byte |
| access_flag | input | 1 | Direct access through the fixed overlay |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| bank_wr_en | input | 1 | Load bank register |
| bank_wr_data | input | 8 | Bank register load value |
| bank_rd | output | 8 | Bank register readback |
| ptr_wr_en | input | 1 | Load a pointer register |
| ptr_wr_idx | input | 2 | Pointer to load |
| ptr_wr_data | input | 12 | Pointer load value |
| eff_addr | output | 12 | Effective address of the current request |
| sfr_sel | output | 1 | Request targets the special-register window |
| sfr_we | output | 1 | Write to the special-register window |
| sfr_addr | output | 8 | Low address byte inside the window |
| sfr_wdata | output | 8 | Write data to the window |
| sfr_rdata | input | 8 | Read data from the window |

## Verification
Some properties are checked by assertions on every cycle. An overlay access must always yield a top nibble of 0x0 or 0xF. A bank load must show up in the readback with its upper nibble cleared. `sfr_sel` must never fire below 0xF60. A read of unimplemented space must return zero on the next cycle, and no RAM write may land past the RAM's end. Other behaviours need the bench's scenarios. These are the exact address for every mode boundary (0x5F/0x60, 0xF5F/0xF60, 0x2FF/0x300), data round-trips through RAM, dropped writes to unimplemented space, and old-value use when a bank or pointer load coincides with an access.

// File: rtl/bau_pkg.sv
package bau_pkg;
    typedef enum logic [1:0] {
        REG_RAM  = 2'd0,
        REG_SFR  = 2'd1,
        REG_NONE = 2'd2
    } region_e;
endpackage

// File: rtl/bau_addr_gen.sv
module bau_addr_gen #(
    parameter int AW        = 12,
    parameter int OW        = 8,
    parameter int BW        = 4,
    parameter int NPTR      = 3,
    parameter int PSW       = 2,
    parameter int ACC_SPLIT = 'h60
) (
    input  logic                     indirect,
    input  logic [PSW-1:0]           ptr_idx,
    input  logic [NPTR-1:0][AW-1:0]  ptrs,
    input  logic [OW-1:0]            opnd,
    input  logic                     acc,
    input  logic [BW-1:0]            bank,
    output logic [AW-1:0]            addr
);
    localparam int HI = AW - OW;

    always_comb begin
        addr = '0;
        if (indirect) begin
            for (int i = 0; i < NPTR; i++) begin
                if (int'(ptr_idx) == i) addr = ptrs[i];
            end
        end else if (acc) begin
            if (int'(opnd) < ACC_SPLIT) addr = {{HI{1'b0}}, opnd};
            else                        addr = {{HI{1'b1}}, opnd};
        end else begin
            addr = {bank, opnd};
        end
    end
endmodule

// File: rtl/bau_region_dec.sv
module bau_region_dec
    import bau_pkg::*;
#(
    parameter int AW       = 12,
    parameter int RAM_TOP  = 'h2FF,
    parameter int SFR_BASE = 'hF60
) (
    input  logic [AW-1:0] addr,
    output region_e       region
);
    always_comb begin
        if (int'(addr) <= RAM_TOP)       region = REG_RAM;
        else if (int'(addr) >= SFR_BASE) region = REG_SFR;
        else                             region = REG_NONE;
    end
endmodule

// File: rtl/bau_ram.sv
module bau_ram #(
    parameter int AW    = 12,
    parameter int DW    = 8,
    parameter int DEPTH = 768
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int IW = $clog2(DEPTH);

    logic [DW-1:0] mem [DEPTH];
    logic          in_range;

    assign in_range = int'(addr) < DEPTH;

    always_ff @(posedge clk) begin
        if (we && in_range) mem[addr[IW-1:0]] <= wdata;
    end

    always_comb begin
        rdata = '0;
        if (in_range) rdata = mem[addr[IW-1:0]];
    end

    // R7: no write request may reach the array beyond its last byte
    p_write_in_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> int'(addr) < DEPTH);
endmodule

// File: rtl/bank_addr_unit.sv
module bank_addr_unit
    import bau_pkg::*;
#(
    parameter int AW        = 12,
    parameter int DW        = 8,
    parameter int OW        = 8,
    parameter int NPTR      = 3,
    parameter int RAM_TOP   = 'h2FF,
    parameter int SFR_BASE  = 'hF60,
    parameter int ACC_SPLIT = 'h60
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic          req_indirect,
    input  logic [1:0]    ptr_sel,
    input  logic [7:0]    opnd,
    input  logic          access_flag,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata,
    input  logic          bank_wr_en,
    input  logic [7:0]    bank_wr_data,
    output logic [7:0]    bank_rd,
    input  logic          ptr_wr_en,
    input  logic [1:0]    ptr_wr_idx,
    input  logic [11:0]   ptr_wr_data,
    output logic [11:0]   eff_addr,
    output logic          sfr_sel,
    output logic          sfr_we,
    output logic [7:0]    sfr_addr,
    output logic [7:0]    sfr_wdata,
    input  logic [7:0]    sfr_rdata
);
    localparam int BW    = AW - OW;
    localparam int DEPTH = RAM_TOP + 1;
    localparam int PSW   = 2;

    typedef struct packed {
        logic [BW-1:0]           bank;
        logic [NPTR-1:0][AW-1:0] ptr;
        logic [DW-1:0]           rdata;
    } state_t;

    state_t        s_d, s_q;
    region_e       region;
    logic [DW-1:0] ram_rdata;
    logic          ram_we;
    logic          rd_req;

    bau_addr_gen #(
        .AW(AW), .OW(OW), .BW(BW), .NPTR(NPTR), .PSW(PSW), .ACC_SPLIT(ACC_SPLIT)
    ) u_agen (
        .indirect (req_indirect),
        .ptr_idx  (ptr_sel),
        .ptrs     (s_q.ptr),
        .opnd     (opnd),
        .acc      (access_flag),
        .bank     (s_q.bank),
        .addr     (eff_addr)
    );

    bau_region_dec #(
        .AW(AW), .RAM_TOP(RAM_TOP), .SFR_BASE(SFR_BASE)
    ) u_dec (
        .addr   (eff_addr),
        .region (region)
    );

    assign ram_we = req_valid && req_write && (region == REG_RAM);
    assign rd_req = req_valid && !req_write;

    bau_ram #(
        .AW(AW), .DW(DW), .DEPTH(DEPTH)
    ) u_ram (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ram_we),
        .addr  (eff_addr),
        .wdata (wdata),
        .rdata (ram_rdata)
    );

    assign sfr_sel   = req_valid && (region == REG_SFR);
    assign sfr_we    = sfr_sel && req_write;
    assign sfr_addr  = eff_addr[OW-1:0];
    assign sfr_wdata = wdata;
    assign rdata     = s_q.rdata;
    assign bank_rd   = {{(DW-BW){1'b0}}, s_q.bank};

    always_comb begin
        s_d = s_q;
        if (bank_wr_en) s_d.bank = bank_wr_data[BW-1:0];
        if (ptr_wr_en) begin
            for (int i = 0; i < NPTR; i++) begin
                if (int'(ptr_wr_idx) == i) s_d.ptr[i] = ptr_wr_data;
            end
        end
        if (rd_req) begin
            unique case (region)
                REG_RAM: s_d.rdata = ram_rdata;
                REG_SFR: s_d.rdata = sfr_rdata;
                default: s_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R3: overlay accesses land only in the bottom or top bank
    p_overlay_banks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_indirect && access_flag)
        |-> (eff_addr[AW-1:OW] == '0 || eff_addr[AW-1:OW] == '1));

    // R2: bank load keeps the low nibble and reads back with zeros above
    p_bank_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bank_wr_en |=> bank_rd == {{(DW-BW){1'b0}}, $past(bank_wr_data[BW-1:0])});

    // R6: window select never fires below the window base
    p_sfr_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sfr_sel |-> int'(eff_addr) >= SFR_BASE);

    // R7: unimplemented reads return zero
    p_unimp_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && region == REG_NONE) |=> rdata == '0);

    // R5: read data holds when no read is requested
    p_rdata_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> $stable(rdata));
endmodule

// File: tb/tb_bank_addr_unit.sv
module tb_bank_addr_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 0, req_write = 0, req_indirect = 0, access_flag = 0;
    logic [1:0]  ptr_sel = 0, ptr_wr_idx = 0;
    logic [7:0]  opnd = 0, wdata = 0, bank_wr_data = 0;
    logic        bank_wr_en = 0, ptr_wr_en = 0;
    logic [11:0] ptr_wr_data = 0;
    logic [7:0]  rdata, bank_rd, sfr_addr, sfr_wdata, sfr_rdata;
    logic [11:0] eff_addr;
    logic        sfr_sel, sfr_we;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    assign sfr_rdata = ~sfr_addr;

    bank_addr_unit dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_indirect(req_indirect),
        .ptr_sel(ptr_sel), .opnd(opnd), .access_flag(access_flag),
        .wdata(wdata), .rdata(rdata),
        .bank_wr_en(bank_wr_en), .bank_wr_data(bank_wr_data), .bank_rd(bank_rd),
        .ptr_wr_en(ptr_wr_en), .ptr_wr_idx(ptr_wr_idx), .ptr_wr_data(ptr_wr_data),
        .eff_addr(eff_addr), .sfr_sel(sfr_sel), .sfr_we(sfr_we),
        .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata)
    );

    // {bank[3:0], opnd[7:0], access_flag, expected address[11:0]}
    localparam logic [24:0] VEC [8] = '{
        {4'h0, 8'h12, 1'b0, 12'h012},
        {4'h5, 8'hAB, 1'b0, 12'h5AB},
        {4'hF, 8'hFF, 1'b0, 12'hFFF},
        {4'hA, 8'h80, 1'b0, 12'hA80},
        {4'h7, 8'h5F, 1'b1, 12'h05F},
        {4'h7, 8'h60, 1'b1, 12'hF60},
        {4'h3, 8'h00, 1'b1, 12'h000},
        {4'h2, 8'hFF, 1'b1, 12'hFFF}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic set_bank(input logic [3:0] b);
        bank_wr_en = 1; bank_wr_data = {4'hC, b};
        step();
        bank_wr_en = 0;
    endtask

    task automatic direct(input logic [3:0] b, input logic [7:0] o, input logic wr, input logic [7:0] d);
        set_bank(b);
        req_valid = 1; req_write = wr; req_indirect = 0; access_flag = 0;
        opnd = o; wdata = d;
        step();
        req_valid = 0; req_write = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst_n = 1;
        // R8: reset state
        chk("R8 bank", bank_rd, 8'h00);
        chk("R8 rdata", rdata, 8'h00);
        req_indirect = 1;
        for (int p = 0; p < 3; p++) begin
            ptr_sel = 2'(p); #1;
            chk("R8 ptr", eff_addr, 12'h000);
        end
        req_indirect = 0;

        // R1 R2 R3: vector table
        for (int i = 0; i < 8; i++) begin
            set_bank(VEC[i][24:21]);
            chk("R2 bank readback", bank_rd, {4'h0, VEC[i][24:21]});
            opnd = VEC[i][20:13]; access_flag = VEC[i][12]; #1;
            chk(VEC[i][12] ? "R3 overlay addr" : "R1 banked addr", eff_addr, VEC[i][11:0]);
        end
        access_flag = 0;

        // R4: pointer path ignores bank
        ptr_wr_en = 1; ptr_wr_idx = 1; ptr_wr_data = 12'h2A5; step();
        ptr_wr_idx = 2; ptr_wr_data = 12'hF7C; step();
        ptr_wr_en = 0;
        set_bank(4'h9);
        req_indirect = 1; ptr_sel = 1; #1;
        chk("R4 ptr1", eff_addr, 12'h2A5);
        ptr_sel = 2; #1;
        chk("R4 ptr2", eff_addr, 12'hF7C);

        // R5: RAM write through pointer, read back direct
        req_valid = 1; req_write = 1; ptr_sel = 1; wdata = 8'h5A; step();
        req_valid = 0; req_write = 0; req_indirect = 0;
        direct(4'h2, 8'hA5, 0, 8'h00);
        chk("R5 ram readback", rdata, 8'h5A);
        direct(4'h2, 8'hFF, 1, 8'h77);
        direct(4'h2, 8'hFF, 0, 8'h00);
        chk("R5 top ram byte", rdata, 8'h77);
        step();
        chk("R5 rdata holds", rdata, 8'h77);

        // R7: unimplemented space
        direct(4'h0, 8'h00, 1, 8'h11);
        direct(4'h2, 8'h00, 1, 8'h22);
        set_bank(4'h3);
        req_valid = 1; req_write = 1; opnd = 8'h00; wdata = 8'hEE; #1;
        chk("R7 no sfr_we", sfr_we, 1'b0);
        step();
        req_valid = 0; req_write = 0;
        direct(4'h3, 8'h00, 0, 8'h00);
        chk("R7 unimpl read", rdata, 8'h00);
        direct(4'h0, 8'h00, 0, 8'h00);
        chk("R7 ram 0x000 untouched", rdata, 8'h11);
        direct(4'h2, 8'h00, 0, 8'h00);
        chk("R7 ram 0x200 untouched", rdata, 8'h22);

        // R6: SFR window
        req_valid = 1; access_flag = 1; opnd = 8'h80; #1;
        chk("R6 sfr_sel", sfr_sel, 1'b1);
        chk("R6 sfr_addr", sfr_addr, 8'h80);
        chk("R6 read no we", sfr_we, 1'b0);
        step();
        req_valid = 0; access_flag = 0;
        chk("R6 sfr read data", rdata, 8'h7F);
        req_valid = 1; req_write = 1; req_indirect = 1; ptr_sel = 2; wdata = 8'h3C; #1;
        chk("R6 sfr_we", sfr_we, 1'b1);
        chk("R6 sfr_wdata", sfr_wdata, 8'h3C);
        chk("R6 sfr_addr ptr", sfr_addr, 8'h7C);
        step();
        req_valid = 0; req_write = 0; req_indirect = 0;
        set_bank(4'hF);
        req_valid = 1; opnd = 8'h5F; #1;
        chk("R6 below window", sfr_sel, 1'b0);
        step();
        req_valid = 0;
        chk("R7 0xF5F reads zero", rdata, 8'h00);

        // R9: same-cycle loads use old values
        set_bank(4'h2);
        bank_wr_en = 1; bank_wr_data = 8'h03;
        req_valid = 1; opnd = 8'hA5; step();
        bank_wr_en = 0; req_valid = 0;
        chk("R9 old bank used", rdata, 8'h5A);
        chk("R9 bank updated", bank_rd, 8'h03);
        ptr_wr_en = 1; ptr_wr_idx = 1; ptr_wr_data = 12'h000;
        req_valid = 1; req_indirect = 1; ptr_sel = 1; step();
        ptr_wr_en = 0; req_valid = 0;
        chk("R9 old ptr used", rdata, 8'h5A);
        #1;
        chk("R9 ptr updated", eff_addr, 12'h000);
        req_indirect = 0;

        // R8: reset keeps RAM, clears registers
        rst_n = 0; step(); rst_n = 1;
        chk("R8 bank after reset", bank_rd, 8'h00);
        chk("R8 rdata after reset", rdata, 8'h00);
        direct(4'h2, 8'hA5, 0, 8'h00);
        chk("R8 ram kept", rdata, 8'h5A);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule